// File: doc/BRIEF.md
# Self-Test Health Gate

This block is the health state machine of a cryptographic module. It watches the outcome of the power-on test sequence, the test checks that run during operation (conditional and critical-function tests), and the signature check applied when a new firmware image is loaded. From these it decides whether cryptographic services may run and whether data may leave the module.

A failure of the power-on sequence, or any operational test failure, moves the block into a critical error. In that state services are off and all data outputs are blocked. Only a reboot, modelled by the reset input, can leave it. A one-cycle alarm pulse tells the host to raise a self-test failure alarm.

A bad firmware signature is handled more gently. The block enters a soft error state, and the firmware already loaded keeps serving traffic. Once the loader reports that the rejected image has been discarded, the block returns to normal operation.

Top module: `selftest_guard`

## Requirements
- R1: The state is reported on `state_code` as RESET=0, POST=1, OPERATIONAL=2, SOFT_ERR=3, CRIT_ERR=4. While reset is held the state is 0. On the first clock edge after release it becomes 1. In states 0 and 1 `svc_enable` is 0 and `out_inhibit` is 1.
- R2: In POST, `post_done`=1 with `post_pass`=1 and no failure strobe moves the block to OPERATIONAL on the next edge. In OPERATIONAL, `svc_enable`=1 and `out_inhibit`=0.
- R3: In POST, `post_done`=1 with `post_pass`=0 moves the block to CRIT_ERR on the next edge.
- R4: Any set bit of `cond_fail` or `crit_fail` seen in POST, OPERATIONAL or SOFT_ERR moves the block to CRIT_ERR on the next edge.
- R5: In CRIT_ERR, `svc_enable`=0 and `out_inhibit`=1. The state stays 4 whatever the other inputs do, until reset.
- R6: `alarm_pulse` is 1 for exactly the first cycle in which the state is CRIT_ERR, and 0 at all other times.
- R7: In OPERATIONAL, `fw_sig_fail`=1 with no failure strobe moves the block to SOFT_ERR. In SOFT_ERR, `svc_enable` stays 1 and `out_inhibit` stays 0.
- R8: In SOFT_ERR, `fw_reject_done`=1 with no failure strobe returns the block to OPERATIONAL on the next edge. Without it, the block stays in SOFT_ERR.
- R9: In SOFT_ERR, a failure strobe has priority over `fw_reject_done` and moves the block to CRIT_ERR.
- R10: In OPERATIONAL, a failure strobe in the same cycle as `fw_sig_fail` moves the block to CRIT_ERR, not to SOFT_ERR.
- R11: In POST, `fw_sig_fail` and `fw_reject_done` have no effect: the state stays 1.
- R12: Asserting reset in CRIT_ERR returns the block to RESET. After release it runs through POST again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; models a reboot |
| post_done | input | 1 | Power-on test sequence has finished |
| post_pass | input | 1 | Power-on test result, valid with post_done |
| cond_fail | input | NUM_COND | Conditional test failure strobes |
| crit_fail | input | NUM_CRIT | Critical-function test failure strobes |
| fw_sig_fail | input | 1 | Firmware image signature check failed |
| fw_reject_done | input | 1 | Failed firmware image has been discarded |
| svc_enable | output | 1 | Cryptographic services allowed |
| out_inhibit | output | 1 | Data outputs blocked |
| state_code | output | 3 | Encoded health state |
| alarm_pulse | output | 1 | One-cycle pulse on entry to critical error |

## Verification
The transition logic is driven through each route into the error states:
- a failing power-on result;
- a single conditional strobe bit and a single critical-function strobe bit;
- failures that coincide with `fw_sig_fail` or with `fw_reject_done`.

These cases separate a wrong priority from a missing transition. Soft errors are raised and cleared both with and without dwell cycles, which shows whether the recovery waits for the reject signal. Firmware strobes applied during POST, and every input toggled while latched in CRIT_ERR, show whether inputs are ignored where they must be. A reset issued from CRIT_ERR followed by a second power-on run shows that only a reboot clears the latch.

// File: rtl/st_guard_pkg.sv
package st_guard_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_POST  = 3'd1,
        ST_OPER  = 3'd2,
        ST_SOFT  = 3'd3,
        ST_CRIT  = 3'd4
    } hstate_e;

    typedef struct packed {
        hstate_e state;
        logic    alarm;
    } core_regs_t;

endpackage

// File: rtl/st_fail_merge.sv
module st_fail_merge #(
    parameter int NUM_COND = 4,
    parameter int NUM_CRIT = 2
) (
    input  logic [NUM_COND-1:0] cond_fail,
    input  logic [NUM_CRIT-1:0] crit_fail,
    output logic                any_fail
);
    localparam int NUM_ALL = NUM_COND + NUM_CRIT;

    logic [NUM_ALL-1:0] all_fail;
    logic [NUM_ALL:0]   chain;

    assign all_fail = {crit_fail, cond_fail};
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < NUM_ALL; i++) begin : g_or
        assign chain[i+1] = chain[i] | all_fail[i];
    end

    assign any_fail = chain[NUM_ALL];
endmodule

// File: rtl/st_state_core.sv
module st_state_core
    import st_guard_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    post_done,
    input  logic    post_pass,
    input  logic    any_fail,
    input  logic    fw_sig_fail,
    input  logic    fw_reject_done,
    output hstate_e state_o,
    output logic    alarm_o
);
    core_regs_t regs_d, regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.alarm = 1'b0;
        unique case (regs_q.state)
            ST_RESET: regs_d.state = ST_POST;
            ST_POST: begin
                if (any_fail)
                    regs_d.state = ST_CRIT;
                else if (post_done)
                    regs_d.state = post_pass ? ST_OPER : ST_CRIT;
            end
            ST_OPER: begin
                if (any_fail)
                    regs_d.state = ST_CRIT;
                else if (fw_sig_fail)
                    regs_d.state = ST_SOFT;
            end
            ST_SOFT: begin
                if (any_fail)
                    regs_d.state = ST_CRIT;
                else if (fw_reject_done)
                    regs_d.state = ST_OPER;
            end
            ST_CRIT: regs_d.state = ST_CRIT;
            default: regs_d.state = ST_CRIT;
        endcase
        regs_d.alarm = (regs_d.state == ST_CRIT) && (regs_q.state != ST_CRIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_RESET, alarm: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;
    assign alarm_o = regs_q.alarm;
endmodule

// File: rtl/st_out_decode.sv
module st_out_decode
    import st_guard_pkg::*;
(
    input  hstate_e    state,
    output logic       svc_enable,
    output logic       out_inhibit,
    output logic [2:0] state_code
);
    logic serving;

    always_comb begin
        unique case (state)
            ST_OPER, ST_SOFT: serving = 1'b1;
            default:          serving = 1'b0;
        endcase
    end

    assign svc_enable  = serving;
    assign out_inhibit = ~serving;
    assign state_code  = state;
endmodule

// File: rtl/selftest_guard.sv
module selftest_guard
    import st_guard_pkg::*;
#(
    parameter int NUM_COND = 4,
    parameter int NUM_CRIT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                post_done,
    input  logic                post_pass,
    input  logic [NUM_COND-1:0] cond_fail,
    input  logic [NUM_CRIT-1:0] crit_fail,
    input  logic                fw_sig_fail,
    input  logic                fw_reject_done,
    output logic                svc_enable,
    output logic                out_inhibit,
    output logic [2:0]          state_code,
    output logic                alarm_pulse
);
    logic    any_fail;
    hstate_e cur_state;

    st_fail_merge #(
        .NUM_COND(NUM_COND),
        .NUM_CRIT(NUM_CRIT)
    ) u_merge (
        .cond_fail(cond_fail),
        .crit_fail(crit_fail),
        .any_fail (any_fail)
    );

    st_state_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .post_done     (post_done),
        .post_pass     (post_pass),
        .any_fail      (any_fail),
        .fw_sig_fail   (fw_sig_fail),
        .fw_reject_done(fw_reject_done),
        .state_o       (cur_state),
        .alarm_o       (alarm_pulse)
    );

    st_out_decode u_dec (
        .state      (cur_state),
        .svc_enable (svc_enable),
        .out_inhibit(out_inhibit),
        .state_code (state_code)
    );
endmodule

// File: rtl/st_guard_chk.sv
module st_guard_chk #(
    parameter int NUM_COND = 4,
    parameter int NUM_CRIT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                post_done,
    input logic                post_pass,
    input logic [NUM_COND-1:0] cond_fail,
    input logic [NUM_CRIT-1:0] crit_fail,
    input logic                fw_reject_done,
    input logic                svc_enable,
    input logic                out_inhibit,
    input logic [2:0]          state_code,
    input logic                alarm_pulse
);
    logic fail_seen;
    logic live_state;

    assign fail_seen  = (|cond_fail) || (|crit_fail);
    assign live_state = (state_code == 3'd1) || (state_code == 3'd2) || (state_code == 3'd3);

    AST_PRE_OPER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code <= 3'd1) |-> (!svc_enable && out_inhibit)); // R1

    AST_POST_FAIL_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1 && post_done && !post_pass) |=> (state_code == 3'd4)); // R3

    AST_FAIL_TO_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
        (live_state && fail_seen) |=> (state_code == 3'd4)); // R4

    AST_CRIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd4) |=> (state_code == 3'd4)); // R5

    AST_CRIT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd4) |-> (!svc_enable && out_inhibit)); // R5

    AST_ALARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |=> !alarm_pulse); // R6

    AST_ALARM_AT_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |-> (state_code == 3'd4)); // R6

    AST_SOFT_SERVING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3) |-> (svc_enable && !out_inhibit)); // R7

    AST_SOFT_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3 && fw_reject_done && !fail_seen) |=> (state_code == 3'd2)); // R8
endmodule

bind selftest_guard st_guard_chk #(
    .NUM_COND(NUM_COND),
    .NUM_CRIT(NUM_CRIT)
) u_guard_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .post_done     (post_done),
    .post_pass     (post_pass),
    .cond_fail     (cond_fail),
    .crit_fail     (crit_fail),
    .fw_reject_done(fw_reject_done),
    .svc_enable    (svc_enable),
    .out_inhibit   (out_inhibit),
    .state_code    (state_code),
    .alarm_pulse   (alarm_pulse)
);

// File: tb/selftest_guard_test.sv
module selftest_guard_test;
    localparam int NC = 4;
    localparam int NK = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          post_done = 1'b0;
    logic          post_pass = 1'b0;
    logic [NC-1:0] cond_fail = '0;
    logic [NK-1:0] crit_fail = '0;
    logic          fw_sig_fail = 1'b0;
    logic          fw_reject_done = 1'b0;
    logic          svc_enable;
    logic          out_inhibit;
    logic [2:0]    state_code;
    logic          alarm_pulse;

    int checks = 0;
    int failures = 0;
    int m_state = 0;
    bit m_alarm = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    selftest_guard #(.NUM_COND(NC), .NUM_CRIT(NK)) uut (
        .clk(clk), .rst_n(rst_n), .post_done(post_done), .post_pass(post_pass),
        .cond_fail(cond_fail), .crit_fail(crit_fail), .fw_sig_fail(fw_sig_fail),
        .fw_reject_done(fw_reject_done), .svc_enable(svc_enable),
        .out_inhibit(out_inhibit), .state_code(state_code), .alarm_pulse(alarm_pulse)
    );

    // behavioural reference model
    function automatic int next_of(int s);
        bit f = (|cond_fail) || (|crit_fail);
        case (s)
            0: return 1;
            1: return f ? 4 : (post_done ? (post_pass ? 2 : 4) : 1);
            2: return f ? 4 : (fw_sig_fail ? 3 : 2);
            3: return f ? 4 : (fw_reject_done ? 2 : 3);
            default: return 4;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0;
            m_alarm = 1'b0;
        end else begin
            int n;
            n = next_of(m_state);
            m_alarm = (n == 4) && (m_state != 4);
            m_state = n;
        end
    end

    function automatic string tag_of(int s);
        case (s)
            0, 1: return "R1";
            2: return "R2";
            3: return "R7";
            default: return "R5";
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            bit exp_svc;
            exp_svc = (m_state == 2) || (m_state == 3);
            checks++;
            if (state_code !== 3'(m_state) || svc_enable !== exp_svc ||
                out_inhibit !== !exp_svc || alarm_pulse !== m_alarm) begin
                failures++;
                $display("FAIL %s cycle model: state=%0d svc=%0b inh=%0b alarm=%0b expected state=%0d svc=%0b inh=%0b alarm=%0b",
                         tag_of(m_state), state_code, svc_enable, out_inhibit, alarm_pulse,
                         m_state, exp_svc, !exp_svc, m_alarm);
            end
        end
    end

    task automatic chk(string tag, int exp_state, bit exp_svc, bit exp_alarm);
        checks++;
        if (state_code !== 3'(exp_state) || svc_enable !== exp_svc ||
            out_inhibit !== !exp_svc || alarm_pulse !== exp_alarm) begin
            failures++;
            $display("FAIL %s: state=%0d svc=%0b inh=%0b alarm=%0b expected state=%0d svc=%0b inh=%0b alarm=%0b",
                     tag, state_code, svc_enable, out_inhibit, alarm_pulse,
                     exp_state, exp_svc, !exp_svc, exp_alarm);
        end
    endtask

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_in();
        post_done = 1'b0; post_pass = 1'b0; cond_fail = '0; crit_fail = '0;
        fw_sig_fail = 1'b0; fw_reject_done = 1'b0;
    endtask

    task automatic reboot();
        @(negedge clk);
        clear_in();
        rst_n = 1'b0;
        cyc(2);
        chk("R1 reset", 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc();
        chk("R1 post entry", 1, 1'b0, 1'b0);
    endtask

    task automatic pass_post();
        post_done = 1'b1; post_pass = 1'b1;
        cyc();
        clear_in();
        chk("R2 post pass", 2, 1'b1, 1'b0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        // power-on, firmware strobes ignored in POST
        reboot();
        cyc(3);
        chk("R1 wait in post", 1, 1'b0, 1'b0);
        fw_sig_fail = 1'b1;
        cyc();
        fw_sig_fail = 1'b0; fw_reject_done = 1'b1;
        cyc();
        clear_in();
        chk("R11 fw ignored in post", 1, 1'b0, 1'b0);
        pass_post();
        cyc(2);
        chk("R2 hold operational", 2, 1'b1, 1'b0);

        // soft error with dwell, then recovery
        fw_sig_fail = 1'b1;
        cyc();
        clear_in();
        chk("R7 soft entry", 3, 1'b1, 1'b0);
        cyc(3);
        chk("R8 soft dwell", 3, 1'b1, 1'b0);
        fw_reject_done = 1'b1;
        cyc();
        clear_in();
        chk("R8 soft exit", 2, 1'b1, 1'b0);

        // immediate reject
        fw_sig_fail = 1'b1;
        cyc();
        fw_sig_fail = 1'b0; fw_reject_done = 1'b1;
        cyc();
        clear_in();
        chk("R8 quick recover", 2, 1'b1, 1'b0);

        // soft error then failure racing reject
        fw_sig_fail = 1'b1;
        cyc();
        fw_sig_fail = 1'b0; fw_reject_done = 1'b1; crit_fail = 2'b10;
        cyc();
        clear_in();
        chk("R9 failure beats reject", 4, 1'b0, 1'b1);
        cyc();
        chk("R6 alarm single", 4, 1'b0, 1'b0);
        post_done = 1'b1; post_pass = 1'b1; fw_reject_done = 1'b1; fw_sig_fail = 1'b1;
        cyc(3);
        clear_in();
        cyc();
        chk("R5 crit latched", 4, 1'b0, 1'b0);

        // reboot from critical, power-on fails
        reboot();
        chk("R12 reboot back to post", 1, 1'b0, 1'b0);
        post_done = 1'b1; post_pass = 1'b0;
        cyc();
        clear_in();
        chk("R3 post fail", 4, 1'b0, 1'b1);

        // single conditional bit in operation
        reboot();
        pass_post();
        cond_fail = 4'b0100;
        cyc();
        clear_in();
        chk("R4 cond fail", 4, 1'b0, 1'b1);

        // critical-function bit coinciding with signature failure
        reboot();
        pass_post();
        crit_fail = 2'b01; fw_sig_fail = 1'b1;
        cyc();
        clear_in();
        chk("R10 fail beats soft", 4, 1'b0, 1'b1);

        // failure during POST
        reboot();
        cond_fail = 4'b0001;
        cyc();
        clear_in();
        chk("R4 fail in post", 4, 1'b0, 1'b1);
        cyc(2);
        chk("R5 outputs blocked", 4, 1'b0, 1'b0);

        cyc();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule